// File: doc/BRIEF.md
# Privilege Tier Guard with Guest Address Relocation

This block holds the processor's privilege state and enforces it. An 8-bit mode word carries the tier in its two low bits: bit 0 switches virtual (guest) addressing on, and bit 1 marks the supervisor tier. Alongside the mode word it keeps the vector table pointer, the kernel stack pointer, and the guest window's base and length. Every cycle it classifies the opcode presented by the decoder. It raises a protection fault when a privileged class is issued from the user tier. It also serves the table-pointer and stack-pointer move instructions.

For memory traffic, the block relocates guest addresses by the window base whenever virtual addressing is on. It bounds-checks them against the window length. A failing access is flagged and its outgoing address is forced to zero so that the memory side can drop it. When an interrupt is entered, the mode returns to kernel and a vector address is formed from the table pointer. The stack pointer reload is requested when the tier being left was user. On an interrupt return, the mode word, base and length are taken from the frame values that the sequencer supplies. Fetching the vector and performing the access are left to neighbouring logic.

Top module: `priv_guard`

## Requirements
- R1: After reset the mode word, table pointer, kernel stack pointer, window base and window length are all zero, so the block starts in the kernel tier.
- R2: Tier decoding uses mode bits [1:0]: 2'b00 kernel, 2'b01 user, 2'b10 supervisor, 2'b11 driver. Bit 0 alone enables guest translation; bits [7:2] are stored but have no effect.
- R3: Opcode classes are coded on op_class as 0 plain, 1 other system op, 2 write table pointer, 3 read table pointer, 4 write kernel stack pointer, 5 read kernel stack pointer, and 6 and 7 plain. Classes 1 to 5 are privileged. With op_valid high, a privileged class in the user tier drives priv_fault high and fault_vec to 3 in the same cycle. No other tier and no other class faults.
- R4: A privileged write that faults leaves the table pointer and kernel stack pointer unchanged.
- R5: Outside the user tier, class 2 or 4 loads op_data into its register at the clock edge. Class 3 or 5 returns that register on rd_data in the same cycle. rd_data is zero otherwise.
- R6: With bit 0 of the mode set, a valid access drives xlat_addr = (acc_addr + base) mod 2^AW. acc_fault is set when acc_addr >= length. acc_fault is never set while acc_valid is low.
- R7: With WRAP_FAULT = 1, a guest access whose relocated sum carries out of AW bits faults.
- R8: With bit 0 of the mode clear, xlat_addr equals acc_addr and acc_fault stays low.
- R9: A cycle with irq_enter high clears the whole mode word at the clock edge. vec_addr is always table pointer + 4 * irq_vec, modulo 2^AW.
- R10: sp_load is high, with sp_value equal to the kernel stack pointer, exactly when irq_enter is high in the user tier.
- R11: iret_strobe loads mode, base and length from iret_mode, iret_base and iret_len at the clock edge, except in the user tier, where it is ignored. irq_enter wins over iret_strobe in the same cycle.
- R12: Whenever an access faults, xlat_addr is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Opcode class below is valid this cycle |
| op_class | input | 3 | Opcode class code (see R3) |
| op_data | input | AW | Source value for pointer writes |
| rd_data | output | AW | Result of pointer reads |
| priv_fault | output | 1 | Privileged class issued from the user tier |
| fault_vec | output | VEC_W | Interrupt number to raise on priv_fault |
| acc_valid | input | 1 | Memory access present |
| acc_addr | input | AW | Guest or physical address of the access |
| xlat_addr | output | AW | Address to use for the access |
| acc_fault | output | 1 | Access rejected by the window check |
| irq_enter | input | 1 | Interrupt entry strobe |
| irq_vec | input | VEC_W | Vector number being entered |
| vec_addr | output | AW | Address of the vector entry |
| sp_load | output | 1 | Reload the stack pointer now |
| sp_value | output | AW | Value for the stack pointer reload |
| iret_strobe | input | 1 | Interrupt return strobe |
| iret_mode | input | MODE_W | Mode word from the frame |
| iret_base | input | AW | Window base from the frame |
| iret_len | input | AW | Window length from the frame |
| cur_mode | output | MODE_W | Current mode word |

## Verification
The bench builds the block with AW = 12, VEC_W = 8 and WRAP_FAULT = 1. With these values every one of the 4096 addresses can be swept under seven window settings, including an empty window, a full window, windows that cross the top of the address space, and the driver tier. All 256 vectors and every tier and class pair are swept too. The narrow address width puts carry-out wrap faults and the length boundary within easy reach. The expected relocation, fault and vector values are computed arithmetically.

// File: rtl/priv_pkg.sv
package priv_pkg;

   localparam int MODE_VIRT_BIT = 0;
   localparam int MODE_SUPV_BIT = 1;

   typedef enum logic [2:0] {
      OPC_PLAIN   = 3'd0,
      OPC_SYSOP   = 3'd1,
      OPC_WR_TBL  = 3'd2,
      OPC_RD_TBL  = 3'd3,
      OPC_WR_KSTK = 3'd4,
      OPC_RD_KSTK = 3'd5,
      OPC_RSV6    = 3'd6,
      OPC_RSV7    = 3'd7
   } op_class_e;

   typedef enum logic [1:0] {
      TIER_KERNEL = 2'b00,
      TIER_USER   = 2'b01,
      TIER_SUPV   = 2'b10,
      TIER_DRIVER = 2'b11
   } tier_e;

   function automatic logic class_is_priv(input op_class_e c);
      return (c == OPC_SYSOP)  || (c == OPC_WR_TBL)  || (c == OPC_RD_TBL) ||
             (c == OPC_WR_KSTK) || (c == OPC_RD_KSTK);
   endfunction

endpackage

// File: rtl/priv_mode_ctl.sv
module priv_mode_ctl
   import priv_pkg::*;
#(
   parameter int AW     = 32,
   parameter int MODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_enter,
   input  logic              iret_strobe,
   input  logic [MODE_W-1:0] iret_mode,
   input  logic [AW-1:0]     iret_base,
   input  logic [AW-1:0]     iret_len,
   output logic [MODE_W-1:0] mode_q,
   output logic [AW-1:0]     base_q,
   output logic [AW-1:0]     len_q,
   output logic              user_tier,
   output logic              virt_on
);

   tier_e tier;
   logic  take_frame;

   assign tier       = tier_e'(mode_q[1:0]);
   assign user_tier  = (tier == TIER_USER);
   assign virt_on    = mode_q[MODE_VIRT_BIT];
   assign take_frame = iret_strobe && !irq_enter && !user_tier;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         base_q <= '0;
         len_q  <= '0;
      end else if (irq_enter) begin
         mode_q <= '0;
      end else if (take_frame) begin
         mode_q <= iret_mode;
         base_q <= iret_base;
         len_q  <= iret_len;
      end
   end

endmodule

// File: rtl/priv_sysregs.sv
module priv_sysregs
   import priv_pkg::*;
#(
   parameter int AW        = 32,
   parameter int VEC_W     = 8,
   parameter int FAULT_VEC = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [2:0]       op_class,
   input  logic [AW-1:0]    op_data,
   input  logic             user_tier,
   input  logic [VEC_W-1:0] irq_vec,
   output logic             priv_fault,
   output logic [VEC_W-1:0] fault_vec,
   output logic [AW-1:0]    rd_data,
   output logic [AW-1:0]    vec_addr,
   output logic [AW-1:0]    tbl_q,
   output logic [AW-1:0]    kstk_q
);

   localparam int PAD_W = AW - VEC_W - 2;
   localparam logic [VEC_W-1:0] FAULT_CODE = VEC_W'(FAULT_VEC);

   op_class_e cls;
   logic      allowed;

   assign cls        = op_class_e'(op_class);
   assign priv_fault = op_valid && user_tier && class_is_priv(cls);
   assign fault_vec  = priv_fault ? FAULT_CODE : '0;
   assign allowed    = op_valid && !priv_fault;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tbl_q  <= '0;
         kstk_q <= '0;
      end else begin
         if (allowed && cls == OPC_WR_TBL)  tbl_q  <= op_data;
         if (allowed && cls == OPC_WR_KSTK) kstk_q <= op_data;
      end
   end

   always_comb begin
      rd_data = '0;
      if (allowed && cls == OPC_RD_TBL)  rd_data = tbl_q;
      if (allowed && cls == OPC_RD_KSTK) rd_data = kstk_q;
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign vec_addr = tbl_q + {{PAD_W{1'b0}}, irq_vec, 2'b00};
      end else begin : g_nopad
         assign vec_addr = tbl_q + {irq_vec, 2'b00};
      end
   endgenerate

endmodule

// File: rtl/priv_xlat.sv
module priv_xlat #(
   parameter int AW         = 32,
   parameter bit WRAP_FAULT = 1'b1
) (
   input  logic          acc_valid,
   input  logic [AW-1:0] acc_addr,
   input  logic          virt_on,
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] len,
   output logic [AW-1:0] xlat_addr,
   output logic          acc_fault
);

   logic [AW-1:0] reloc;
   logic          carry;
   logic          over_len;
   logic          bad;

   generate
      if (WRAP_FAULT) begin : g_wrap
         logic [AW:0] wide;
         assign wide  = {1'b0, acc_addr} + {1'b0, base};
         assign reloc = wide[AW-1:0];
         assign carry = wide[AW];
      end else begin : g_nowrap
         assign reloc = acc_addr + base;
         assign carry = 1'b0;
      end
   endgenerate

   assign over_len  = (acc_addr >= len);
   assign bad       = acc_valid && virt_on && (over_len || carry);
   assign acc_fault = bad;

   always_comb begin
      if (bad)          xlat_addr = '0;
      else if (virt_on) xlat_addr = reloc;
      else              xlat_addr = acc_addr;
   end

endmodule

// File: rtl/priv_guard.sv
module priv_guard
   import priv_pkg::*;
#(
   parameter int AW         = 32,
   parameter int MODE_W     = 8,
   parameter int VEC_W      = 8,
   parameter int FAULT_VEC  = 3,
   parameter bit WRAP_FAULT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [2:0]        op_class,
   input  logic [AW-1:0]     op_data,
   output logic [AW-1:0]     rd_data,
   output logic              priv_fault,
   output logic [VEC_W-1:0]  fault_vec,
   input  logic              acc_valid,
   input  logic [AW-1:0]     acc_addr,
   output logic [AW-1:0]     xlat_addr,
   output logic              acc_fault,
   input  logic              irq_enter,
   input  logic [VEC_W-1:0]  irq_vec,
   output logic [AW-1:0]     vec_addr,
   output logic              sp_load,
   output logic [AW-1:0]     sp_value,
   input  logic              iret_strobe,
   input  logic [MODE_W-1:0] iret_mode,
   input  logic [AW-1:0]     iret_base,
   input  logic [AW-1:0]     iret_len,
   output logic [MODE_W-1:0] cur_mode
);

   generate
      if (MODE_W < 2) begin : g_bad_mode
         $error("priv_guard: MODE_W must hold the two tier bits");
      end
      if (AW < VEC_W + 2) begin : g_bad_aw
         $error("priv_guard: AW too narrow for the vector offset");
      end
      if (FAULT_VEC >= (1 << VEC_W)) begin : g_bad_fv
         $error("priv_guard: FAULT_VEC does not fit in VEC_W");
      end
   endgenerate

   logic [AW-1:0] base_w;
   logic [AW-1:0] len_w;
   logic [AW-1:0] tbl_w;
   logic [AW-1:0] kstk_w;
   logic          user_tier;
   logic          virt_on;

   priv_mode_ctl #(.AW(AW), .MODE_W(MODE_W)) u_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq_enter  (irq_enter),
      .iret_strobe(iret_strobe),
      .iret_mode  (iret_mode),
      .iret_base  (iret_base),
      .iret_len   (iret_len),
      .mode_q     (cur_mode),
      .base_q     (base_w),
      .len_q      (len_w),
      .user_tier  (user_tier),
      .virt_on    (virt_on)
   );

   priv_sysregs #(.AW(AW), .VEC_W(VEC_W), .FAULT_VEC(FAULT_VEC)) u_sys (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_valid  (op_valid),
      .op_class  (op_class),
      .op_data   (op_data),
      .user_tier (user_tier),
      .irq_vec   (irq_vec),
      .priv_fault(priv_fault),
      .fault_vec (fault_vec),
      .rd_data   (rd_data),
      .vec_addr  (vec_addr),
      .tbl_q     (tbl_w),
      .kstk_q    (kstk_w)
   );

   priv_xlat #(.AW(AW), .WRAP_FAULT(WRAP_FAULT)) u_xlat (
      .acc_valid(acc_valid),
      .acc_addr (acc_addr),
      .virt_on  (virt_on),
      .base     (base_w),
      .len      (len_w),
      .xlat_addr(xlat_addr),
      .acc_fault(acc_fault)
   );

   assign sp_load  = irq_enter && user_tier;
   assign sp_value = kstk_w;

endmodule

// File: rtl/priv_guard_chk.sv
module priv_guard_chk #(
   parameter int AW        = 32,
   parameter int MODE_W    = 8,
   parameter int VEC_W     = 8,
   parameter int FAULT_VEC = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [2:0]        op_class,
   input logic              priv_fault,
   input logic [VEC_W-1:0]  fault_vec,
   input logic              acc_valid,
   input logic [AW-1:0]     acc_addr,
   input logic [AW-1:0]     xlat_addr,
   input logic              acc_fault,
   input logic              irq_enter,
   input logic              sp_load,
   input logic              iret_strobe,
   input logic [MODE_W-1:0] iret_mode,
   input logic [MODE_W-1:0] cur_mode,
   input logic [AW-1:0]     len_w,
   input logic [AW-1:0]     tbl_w,
   input logic [AW-1:0]     kstk_w
);

   logic in_user;
   assign in_user = (cur_mode[1:0] == 2'b01);

   AST_USER_PRIV_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && in_user && op_class >= 3'd1 && op_class <= 3'd5
      |-> priv_fault && fault_vec == VEC_W'(FAULT_VEC)); // R3

   AST_NO_FAULT_OUTSIDE_USER: assert property (@(posedge clk) disable iff (!rst_n)
      !in_user |-> !priv_fault); // R3

   AST_FAULTED_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      priv_fault |=> $stable(tbl_w) && $stable(kstk_w)); // R4

   AST_PASSTHROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && !cur_mode[0] |-> xlat_addr == acc_addr && !acc_fault); // R8

   AST_BOUND_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && cur_mode[0] && acc_addr >= len_w |-> acc_fault); // R6

   AST_IDLE_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> !acc_fault); // R6

   AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      acc_fault |-> xlat_addr == '0); // R12

   AST_ENTRY_KERNEL: assert property (@(posedge clk) disable iff (!rst_n)
      irq_enter |=> cur_mode == '0); // R9

   AST_SP_LOAD_USER: assert property (@(posedge clk) disable iff (!rst_n)
      sp_load |-> irq_enter && in_user); // R10

   AST_IRET_IGNORED_USER: assert property (@(posedge clk) disable iff (!rst_n)
      iret_strobe && !irq_enter && in_user |=> $stable(cur_mode)); // R11

   AST_IRET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      iret_strobe && !irq_enter && !in_user |=> cur_mode == $past(iret_mode)); // R11

endmodule

bind priv_guard priv_guard_chk #(
   .AW(AW), .MODE_W(MODE_W), .VEC_W(VEC_W), .FAULT_VEC(FAULT_VEC)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .op_valid   (op_valid),
   .op_class   (op_class),
   .priv_fault (priv_fault),
   .fault_vec  (fault_vec),
   .acc_valid  (acc_valid),
   .acc_addr   (acc_addr),
   .xlat_addr  (xlat_addr),
   .acc_fault  (acc_fault),
   .irq_enter  (irq_enter),
   .sp_load    (sp_load),
   .iret_strobe(iret_strobe),
   .iret_mode  (iret_mode),
   .cur_mode   (cur_mode),
   .len_w      (len_w),
   .tbl_w      (tbl_w),
   .kstk_w     (kstk_w)
);

// File: tb/sim_priv_guard.sv
module sim_priv_guard;

   localparam int CLK_PERIOD = 10;
   localparam int AW  = 12;
   localparam int MW  = 8;
   localparam int VW  = 8;
   localparam int SPAN = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          op_valid;
   logic [2:0]    op_class;
   logic [AW-1:0] op_data;
   logic [AW-1:0] rd_data;
   logic          priv_fault;
   logic [VW-1:0] fault_vec;
   logic          acc_valid;
   logic [AW-1:0] acc_addr;
   logic [AW-1:0] xlat_addr;
   logic          acc_fault;
   logic          irq_enter;
   logic [VW-1:0] irq_vec;
   logic [AW-1:0] vec_addr;
   logic          sp_load;
   logic [AW-1:0] sp_value;
   logic          iret_strobe;
   logic [MW-1:0] iret_mode;
   logic [AW-1:0] iret_base;
   logic [AW-1:0] iret_len;
   logic [MW-1:0] cur_mode;

   int checks = 0;
   int errors = 0;
   int exp_tbl = 0;
   int exp_kstk = 0;
   int tier = 0;

   priv_guard #(.AW(AW), .MODE_W(MW), .VEC_W(VW), .FAULT_VEC(3), .WRAP_FAULT(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
      .op_data(op_data), .rd_data(rd_data), .priv_fault(priv_fault),
      .fault_vec(fault_vec), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .xlat_addr(xlat_addr), .acc_fault(acc_fault), .irq_enter(irq_enter),
      .irq_vec(irq_vec), .vec_addr(vec_addr), .sp_load(sp_load),
      .sp_value(sp_value), .iret_strobe(iret_strobe), .iret_mode(iret_mode),
      .iret_base(iret_base), .iret_len(iret_len), .cur_mode(cur_mode)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   task automatic enter_irq(input int v);
      @(negedge clk);
      irq_enter = 1'b1;
      irq_vec   = VW'(v);
      #1;
      check("R9 vector address", int'(vec_addr), (exp_tbl + 4 * v) % SPAN);
      check("R10 sp_load", int'(sp_load), (tier == 1) ? 1 : 0);
      if (tier == 1) check("R10 sp_value", int'(sp_value), exp_kstk);
      @(negedge clk);
      irq_enter = 1'b0;
      check("R9 mode cleared on entry", int'(cur_mode), 0);
      tier = 0;
   endtask

   task automatic do_iret(input int m, input int b, input int l);
      @(negedge clk);
      iret_strobe = 1'b1;
      iret_mode   = MW'(m);
      iret_base   = AW'(b);
      iret_len    = AW'(l);
      @(negedge clk);
      iret_strobe = 1'b0;
      if (tier != 1) tier = m % 4;
   endtask

   task automatic do_op(input int c, input int d, output logic f, output int rd, output int fv);
      @(negedge clk);
      op_valid = 1'b1;
      op_class = 3'(c);
      op_data  = AW'(d);
      #1;
      f  = priv_fault;
      rd = int'(rd_data);
      fv = int'(fault_vec);
      @(negedge clk);
      op_valid = 1'b0;
   endtask

   task automatic sweep_window(input int b, input int l, input bit virt);
      acc_valid = 1'b1;
      for (int a = 0; a < SPAN; a++) begin
         int s;
         int ef;
         int ex;
         acc_addr = AW'(a);
         #1;
         s  = a + b;
         ef = (virt && (a >= l || s >= SPAN)) ? 1 : 0;
         ex = ef ? 0 : (virt ? s % SPAN : a);
         if (virt) begin
            check("R6 R7 window fault", int'(acc_fault), ef);
            check("R6 R12 relocated address", int'(xlat_addr), ex);
         end else begin
            check("R8 pass-through fault", int'(acc_fault), 0);
            check("R8 pass-through address", int'(xlat_addr), a);
         end
      end
      acc_valid = 1'b0;
      #1;
      check("R6 no fault when idle", int'(acc_fault), 0);
   endtask

   initial begin
      logic f;
      int rd;
      int fv;
      int cb[7] = '{0, 0, 7, 4000, 2048, 4095, 5};
      int cl[7] = '{0, 4095, 100, 4095, 2049, 1, 10};

      rst_n = 1'b0;
      op_valid = 1'b0; op_class = '0; op_data = '0;
      acc_valid = 1'b0; acc_addr = '0;
      irq_enter = 1'b0; irq_vec = '0;
      iret_strobe = 1'b0; iret_mode = '0; iret_base = '0; iret_len = '0;
      repeat (3) @(negedge clk);
      check("R1 reset mode", int'(cur_mode), 0);
      rst_n = 1'b1;

      do_op(3, 0, f, rd, fv);
      check("R1 reset table pointer", rd, 0);
      do_op(5, 0, f, rd, fv);
      check("R1 reset kernel stack pointer", rd, 0);

      exp_tbl = 'h123;
      do_op(2, exp_tbl, f, rd, fv);
      exp_kstk = 'h456;
      do_op(4, exp_kstk, f, rd, fv);
      do_op(3, 0, f, rd, fv);
      check("R5 read table pointer", rd, exp_tbl);
      do_op(5, 0, f, rd, fv);
      check("R5 read kernel stack pointer", rd, exp_kstk);

      sweep_window(0, 0, 1'b0);

      for (int k = 0; k < 7; k++) begin
         enter_irq(k);
         do_iret((k == 6) ? 3 : 1, cb[k], cl[k]);
         check("R2 tier after return", int'(cur_mode), (k == 6) ? 3 : 1);
         sweep_window(cb[k], cl[k], 1'b1);
      end

      for (int m = 0; m < 4; m++) begin
         enter_irq(m + 20);
         do_iret(m, 0, SPAN - 1);
         for (int c = 0; c < 8; c++) begin
            int d;
            int ef;
            ef = (m == 1 && c >= 1 && c <= 5) ? 1 : 0;
            d  = (m == 1) ? 'hABC : ((c == 4) ? exp_kstk : exp_tbl);
            do_op(c, d, f, rd, fv);
            check("R3 privilege fault", int'(f), ef);
            check("R3 fault vector", fv, ef ? 3 : 0);
            if (c == 3) check("R5 R4 table pointer read", rd, ef ? 0 : exp_tbl);
            if (c == 5) check("R5 R4 kstack pointer read", rd, ef ? 0 : exp_kstk);
         end
      end

      enter_irq(1);
      do_op(3, 0, f, rd, fv);
      check("R4 table pointer kept after faulted write", rd, exp_tbl);
      do_op(5, 0, f, rd, fv);
      check("R4 kstack pointer kept after faulted write", rd, exp_kstk);

      do_iret(1, 0, 16);
      do_iret(0, 0, 0);
      check("R11 return ignored in user tier", int'(cur_mode), 1);

      @(negedge clk);
      irq_enter = 1'b1; irq_vec = 8'd9;
      iret_strobe = 1'b1; iret_mode = 8'h02;
      #1;
      check("R10 sp_load from user", int'(sp_load), 1);
      check("R10 sp_value from user", int'(sp_value), exp_kstk);
      @(negedge clk);
      irq_enter = 1'b0; iret_strobe = 1'b0;
      check("R11 entry wins over return", int'(cur_mode), 0);
      tier = 0;

      do_iret('hA6, 0, 0);
      check("R11 full mode word loaded", int'(cur_mode), 'hA6);
      do_op(1, 0, f, rd, fv);
      check("R2 upper bits ignored, supervisor tier", int'(f), 0);

      enter_irq(255);
      for (int v = 0; v < 256; v++) begin
         irq_vec = VW'(v);
         #1;
         check("R9 vector sweep", int'(vec_addr), (exp_tbl + 4 * v) % SPAN);
         check("R10 no reload from kernel", int'(sp_load), 0);
      end

      summary();
      $finish;
   end

endmodule